// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block produces the running colour subcarrier phase for a composite video encoder. A 32-bit phase accumulator adds a frequency control word on every cycle of its clock, which runs at twice the pixel rate, and wraps modulo 2^32. The top bits of the accumulator are the output phase, which a downstream sine table and chroma modulator consume.

The frequency word comes from one of three places. It can be a built-in tuning word picked by a 2-bit colour standard code, or a programmed custom word. In the line-alternating FM colour mode, the programmed word is the red-difference centre frequency. There it alternates line by line with a separately programmed blue-difference centre frequency. Both programmed words are written 16 bits at a time through a small write port.

At every line start the accumulator reloads an 8-bit phase offset, where one step is 360/256 degrees. The block then raises a one-cycle line phase reset output. A synchronous soft clear returns the accumulator and the line parity to their initial state.

Top module: `chroma_phase_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator, line parity and `line_rst` clear to 0. The custom word clears to 0 and the blue-difference word takes the value 0x284BDA13.
- R2: On an edge with neither `soft_clr` nor `line_start`, the accumulator adds the selected word. `phase` shows accumulator bits [31:24].
- R3: With `custom_en` and `secam_en` both 0, `std_sel` picks the word. Code 0 gives 0x21F07C1F, 1 gives 0x2A098ACB, 2 gives 0x21E6EFE3 and 3 gives 0x21F69446.
- R4: With `custom_en` 1 and `secam_en` 0, the word is the programmed custom word.
- R5: A write with `cfg_wr` high updates one 16-bit half. `cfg_addr` bit 1 picks the bank (0 custom, 1 blue-difference) and bit 0 picks the half (0 low, 1 high). Only that half changes, and the new value is used from the following edge.
- R6: With `secam_en` 1, line parity 0 uses the custom word whatever `custom_en` is, and parity 1 uses the blue-difference word.
- R7: An edge with `line_start` high and `soft_clr` low loads `{phase_ofs, 24'h0}` into the accumulator. `line_rst` is high for exactly the cycle after each such edge.
- R8: Line parity toggles on a line start only when `secam_en` is 1.
- R9: `soft_clr` clears the accumulator, the parity and `line_rst`, and takes priority over `line_start`.
- R10: The accumulator wraps modulo 2^32. A word of 0x80000000 makes `phase` alternate between 0x80 and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of accumulator and parity |
| cfg_wr | input | 1 | Write strobe for the word registers |
| cfg_addr | input | 2 | Bit 1 bank (custom / blue-difference), bit 0 half |
| cfg_wdata | input | 16 | Half-word write data |
| std_sel | input | 2 | Colour standard code for the built-in word |
| custom_en | input | 1 | Use the programmed custom word |
| secam_en | input | 1 | Line-alternating FM colour mode |
| phase_ofs | input | 8 | Phase offset reloaded at line start |
| line_start | input | 1 | Line start strobe |
| phase | output | 8 | Subcarrier phase |
| line_rst | output | 1 | Line phase reset pulse |

## Verification
A configuration write is used from the first edge after the edge that stores it. The reload value and `line_rst` appear one edge after a `line_start` edge. After a clear or reload, the phase after K further edges is the top byte of the start value plus K times the word. The bench drives inputs on falling edges and counts exactly K falling edges before it samples. Each expected phase is computed in 64-bit arithmetic from the word the requirement names.

// File: rtl/chroma_phase_pkg.sv
// Shared constants and types for the colour subcarrier phase generator.
// Assumes a 32-bit tuning word where 2^31 equals the pixel rate.
package chroma_phase_pkg;
    localparam int FCW_W  = 32;
    localparam int HALF_W = FCW_W / 2;

    typedef enum logic [1:0] {
        STD_NTSC  = 2'd0,
        STD_PAL   = 2'd1,
        STD_PAL_M = 2'd2,
        STD_PAL_N = 2'd3
    } tv_std_e;

    localparam logic [FCW_W-1:0] FCW_NTSC   = 32'h21F0_7C1F;
    localparam logic [FCW_W-1:0] FCW_PAL    = 32'h2A09_8ACB;
    localparam logic [FCW_W-1:0] FCW_PAL_M  = 32'h21E6_EFE3;
    localparam logic [FCW_W-1:0] FCW_PAL_N  = 32'h21F6_9446;
    localparam logic [FCW_W-1:0] FCW_DB_RST = 32'h284B_DA13;

    // Built-in tuning word for a colour standard code.
    function automatic logic [FCW_W-1:0] builtin_fcw(tv_std_e s);
        case (s)
            STD_NTSC:  return FCW_NTSC;
            STD_PAL:   return FCW_PAL;
            STD_PAL_M: return FCW_PAL_M;
            default:   return FCW_PAL_N;
        endcase
    endfunction
endpackage

// File: rtl/cpg_word_regs.sv
// Holds the programmed custom (red-difference) word and the blue-difference word.
// Each is written as two 16-bit halves. Address bit 1 selects the bank and
// bit 0 the half. Assumes one write per cycle at most.
module cpg_word_regs
    import chroma_phase_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [HALF_W-1:0] cfg_wdata,
    output logic [FCW_W-1:0]  cust_word,
    output logic [FCW_W-1:0]  db_word
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] cust_h;
        logic [HALF_W-1:0] db_h;
        logic              hit_h;

        // Decode a write aimed at this half.
        assign hit_h = cfg_wr && (cfg_addr[0] == 1'(h));

        // Store the custom and blue-difference halves.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cust_h <= '0;
                db_h   <= FCW_DB_RST[h*HALF_W +: HALF_W];
            end else if (hit_h) begin
                if (!cfg_addr[1]) cust_h <= cfg_wdata;
                else              db_h   <= cfg_wdata;
            end
        end

        assign cust_word[h*HALF_W +: HALF_W] = cust_h;
        assign db_word[h*HALF_W +: HALF_W]   = db_h;
    end

    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(cust_word) && $stable(db_word)));
endmodule

// File: rtl/cpg_word_sel.sv
// Chooses the tuning word for the current cycle. The FM colour mode takes
// priority, then the custom override, then the built-in word per standard.
// Purely combinational.
module cpg_word_sel
    import chroma_phase_pkg::*;
(
    input  logic [1:0]       std_sel,
    input  logic             custom_en,
    input  logic             secam_en,
    input  logic             line_par,
    input  logic [FCW_W-1:0] cust_word,
    input  logic [FCW_W-1:0] db_word,
    output logic [FCW_W-1:0] sel_word
);
    // Priority selection of the active tuning word.
    always_comb begin
        if (secam_en)       sel_word = line_par ? db_word : cust_word;
        else if (custom_en) sel_word = cust_word;
        else                sel_word = builtin_fcw(tv_std_e'(std_sel));
    end
endmodule

// File: rtl/cpg_phase_acc.sv
// Phase accumulator with line-start reload and the line parity flag.
// Advances once per clock and wraps modulo 2^FCW_W. The output phase is
// the top PH_W bits.
module cpg_phase_acc
    import chroma_phase_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             line_start,
    input  logic             secam_en,
    input  logic [PH_W-1:0]  phase_ofs,
    input  logic [FCW_W-1:0] sel_word,
    output logic [PH_W-1:0]  phase,
    output logic             line_rst,
    output logic             line_par
);
    localparam int LOW_W = FCW_W - PH_W;

    logic [FCW_W-1:0] acc_q;

    // Accumulate, reload at line start, toggle the parity in FM mode.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            acc_q    <= '0;
            line_par <= 1'b0;
            line_rst <= 1'b0;
        end else begin
            line_rst <= line_start;
            if (line_start) begin
                acc_q <= {phase_ofs, {LOW_W{1'b0}}};
                if (secam_en) line_par <= ~line_par;
            end else begin
                acc_q <= acc_q + sel_word;
            end
        end
    end

    assign phase = acc_q[FCW_W-1 -: PH_W];

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && !line_start) |=> (acc_q == $past(acc_q) + $past(sel_word)));
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !soft_clr) |=> (phase == $past(phase_ofs) && line_rst));
    a_r8_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!secam_en && !soft_clr) |=> $stable(line_par));
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (acc_q == '0 && !line_par && !line_rst));
endmodule

// File: rtl/chroma_phase_gen.sv
// Colour subcarrier phase generator top level. It joins the word registers,
// the word selector and the phase accumulator. Assumes the clock runs at
// twice the pixel rate and that all inputs are synchronous to it.
module chroma_phase_gen
    import chroma_phase_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [HALF_W-1:0] cfg_wdata,
    input  logic [1:0]        std_sel,
    input  logic              custom_en,
    input  logic              secam_en,
    input  logic [PH_W-1:0]   phase_ofs,
    input  logic              line_start,
    output logic [PH_W-1:0]   phase,
    output logic              line_rst
);
    logic [FCW_W-1:0] cust_word;
    logic [FCW_W-1:0] db_word;
    logic [FCW_W-1:0] sel_word;
    logic             line_par;

    cpg_word_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cust_word (cust_word),
        .db_word   (db_word)
    );

    cpg_word_sel u_sel (
        .std_sel   (std_sel),
        .custom_en (custom_en),
        .secam_en  (secam_en),
        .line_par  (line_par),
        .cust_word (cust_word),
        .db_word   (db_word),
        .sel_word  (sel_word)
    );

    cpg_phase_acc #(.PH_W(PH_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .line_start (line_start),
        .secam_en   (secam_en),
        .phase_ofs  (phase_ofs),
        .sel_word   (sel_word),
        .phase      (phase),
        .line_rst   (line_rst),
        .line_par   (line_par)
    );

    a_r6_secam_word: assert property (@(posedge clk) disable iff (!rst_n)
        secam_en |-> (sel_word == (line_par ? db_word : cust_word)));
endmodule

// File: tb/chroma_phase_gen_tb.sv
module chroma_phase_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K = 300;
    localparam logic [31:0] DB_DEF = 32'h284B_DA13;
    localparam logic [31:0] CUST   = 32'h1234_5678;

    // {std[1:0], custom_en, secam_en, expected word[31:0]}
    localparam logic [35:0] VEC [7] = '{
        {2'd0, 1'b0, 1'b0, 32'h21F0_7C1F},
        {2'd1, 1'b0, 1'b0, 32'h2A09_8ACB},
        {2'd2, 1'b0, 1'b0, 32'h21E6_EFE3},
        {2'd3, 1'b0, 1'b0, 32'h21F6_9446},
        {2'd1, 1'b1, 1'b0, CUST},
        {2'd0, 1'b0, 1'b1, CUST},
        {2'd2, 1'b1, 1'b1, CUST}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [1:0]  std_sel = '0;
    logic        custom_en = 1'b0;
    logic        secam_en = 1'b0;
    logic [7:0]  phase_ofs = 8'h28;
    logic        line_start = 1'b0;
    logic [7:0]  phase;
    logic        line_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    chroma_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .std_sel(std_sel),
        .custom_en(custom_en), .secam_en(secam_en), .phase_ofs(phase_ofs),
        .line_start(line_start), .phase(phase), .line_rst(line_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_ph(logic [31:0] base, logic [31:0] w, int k);
        logic [63:0] t;
        t = 64'(base) + 64'(w) * 64'(k);
        return t[31:24];
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clr();
        soft_clr = 1'b1;
        cyc(1);
        soft_clr = 1'b0;
    endtask

    task automatic line();
        line_start = 1'b1;
        cyc(1);
        line_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 phase", 32'(phase), 0);
        chk("R1 line_rst", 32'(line_rst), 0);

        // R1/R6: custom word resets to 0, Db to its default
        secam_en = 1'b1;
        clr();
        cyc(K);
        chk("R1 custom zero", 32'(phase), 0);
        clr();
        line();
        chk("R7 line_rst", 32'(line_rst), 1);
        chk("R7 offset 0x28", 32'(phase), 32'h28);
        cyc(1);
        chk("R7 single pulse", 32'(line_rst), 0);
        cyc(K - 1);
        chk("R1 R6 Db default", 32'(phase), 32'(exp_ph({8'h28, 24'h0}, DB_DEF, K)));

        // R5: program the custom word in halves
        wr(2'd1, CUST[31:16]);
        wr(2'd0, CUST[15:0]);

        // R2 R3 R4 R6: table walk
        foreach (VEC[i]) begin
            std_sel = VEC[i][35:34];
            custom_en = VEC[i][33];
            secam_en = VEC[i][32];
            clr();
            cyc(K);
            chk($sformatf("R2 R3 R4 R6 vec %0d", i), 32'(phase),
                32'(exp_ph(32'h0, VEC[i][31:0], K)));
        end

        // R8: a line start outside FM mode leaves the parity alone
        phase_ofs = 8'hC3;
        secam_en = 1'b0; custom_en = 1'b0;
        clr();
        line();
        secam_en = 1'b1;
        line();
        cyc(K);
        chk("R8 parity held", 32'(phase), 32'(exp_ph({8'hC3, 24'h0}, DB_DEF, K)));
        // R6: next line returns to the red-difference word
        line();
        cyc(K);
        chk("R6 alternate", 32'(phase), 32'(exp_ph({8'hC3, 24'h0}, CUST, K)));

        // R9: soft clear beats line start and clears parity
        line();
        soft_clr = 1'b1; line_start = 1'b1;
        cyc(1);
        soft_clr = 1'b0; line_start = 1'b0;
        chk("R9 no line_rst", 32'(line_rst), 0);
        chk("R9 phase clear", 32'(phase), 0);
        cyc(K);
        chk("R9 parity clear", 32'(phase), 32'(exp_ph(32'h0, CUST, K)));

        // R5: Db bank writes
        wr(2'd3, 16'h3000);
        wr(2'd2, 16'h0001);
        clr();
        line();
        cyc(K);
        chk("R5 Db write", 32'(phase), 32'(exp_ph({8'hC3, 24'h0}, 32'h3000_0001, K)));

        // R5: a low-half write leaves the high half
        wr(2'd0, 16'hFFFF);
        secam_en = 1'b0; custom_en = 1'b1;
        clr();
        cyc(K);
        chk("R5 half only", 32'(phase), 32'(exp_ph(32'h0, 32'h1234_FFFF, K)));

        // R10: wrap
        wr(2'd1, 16'h8000);
        wr(2'd0, 16'h0000);
        clr();
        cyc(1);
        chk("R10 half turn", 32'(phase), 32'h80);
        cyc(1);
        chk("R10 wrap", 32'(phase), 32'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule